// File: doc/BRIEF.md
# External Code-Fetch Bus Controller

This block runs one code-fetch transaction at a time on a multiplexed external program-memory bus. The CPU core gives it a 16-bit fetch address and a table-read flag together with a one-clock start request. The controller then drives the high address byte on a dedicated upper address port. It sends the low address byte on the shared byte bus and raises the address-latch strobe so that an external latch can capture that byte. It then lowers the program-store strobe and releases the shared bus so that the memory can drive its data onto it. The data byte is captured as the strobe rises. The byte goes back to the core with a one-clock valid pulse.

The block is clocked by the oscillator. A CPU-clock enable sets the pace of the transaction. In standard mode this enable ticks on every second oscillator clock, and in double-speed mode it ticks on every oscillator clock. A transaction always lasts six CPU clocks, which is 12 or 6 oscillator clocks. Code fetches and table reads use the same strobe sequence. The shared bus is modelled as a separate output, output-enable and input, and the pad ring combines them into a tri-state pin.

Top module: `xfetch_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, `psen_n_o`=1, `ale_o`=0, `ad_oe_o`=0 and `busy`=0. `rsp_valid` is 0 after reset.
- R2: A start that is accepted at an oscillator edge keeps `busy` high for 6 CPU phases. One phase is 2 oscillator clocks when `double_speed`=0 and 1 oscillator clock when `double_speed`=1, so `busy` stays high for 12 or 6 oscillator clocks.
- R3: For the whole transaction, `addr_hi_o` equals bits 15:8 of the accepted address.
- R4: In phase 0, `ale_o`=1, `ad_oe_o`=1, `psen_n_o`=1, and `ad_out_o` equals bits 7:0 of the address.
- R5: In phase 1, `ale_o`=0 while `ad_oe_o` stays 1 with the same low address byte, and `psen_n_o`=1. The latch strobe therefore falls before the bus is released.
- R6: In phases 2, 3 and 4, `psen_n_o`=0, `ad_oe_o`=0 and `ale_o`=0. In phase 5, `psen_n_o`=1 and `ad_oe_o`=0.
- R7: `ad_in_i` is sampled at the CPU-clock edge that ends phase 4, which is the edge where `psen_n_o` rises. `rsp_valid` is high for exactly one oscillator clock after the edge that ends phase 5. `rsp_data` then carries the sampled byte and `busy` is 0.
- R8: A start request that arrives while `busy`=1 is ignored. Address, timing and returned data all stay those of the transaction in progress.
- R9: `double_speed` is sampled only when a transaction starts. A change while `busy`=1 does not alter the length of the current transaction.
- R10: A table read (`req_table`=1) uses the same strobe sequence as a code fetch, and the flag is returned on `rsp_table` together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| double_speed | input | 1 | 1: one CPU clock per oscillator clock; 0: one per two |
| req_start | input | 1 | Start request, taken when idle |
| req_addr | input | 16 | Fetch address |
| req_table | input | 1 | 1 marks a table-read access |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-clock pulse, fetched byte available |
| rsp_data | output | 8 | Fetched byte |
| rsp_table | output | 1 | Table-read flag of the finished transaction |
| addr_hi_o | output | 8 | Upper address port |
| ad_out_o | output | 8 | Low address driven on the shared bus |
| ad_oe_o | output | 1 | Output enable of the shared bus |
| ad_in_i | input | 8 | Value read from the shared bus |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-store strobe, active low |

## Verification
The assertions assume that `rst_n` is applied before the first transaction. They also assume that the memory drives `ad_in_i` only while `psen_n_o` is low. No assertion depends on when `req_start` or `double_speed` change. The bench drives every input on the falling clock edge. Its memory model drives a fixed filler byte whenever the strobe is high, so a capture taken at the wrong edge returns that filler instead of the memory value. The bench raises start requests and flips the mode bit only inside a transaction, which keeps those stimuli within what R8 and R9 promise.

// File: rtl/xfetch_pkg.sv
package xfetch_pkg;

  localparam int unsigned NUM_PHASES = 6;

  typedef enum logic [2:0] {
    PH_ADDR  = 3'd0,
    PH_HOLD  = 3'd1,
    PH_RD0   = 3'd2,
    PH_RD1   = 3'd3,
    PH_RD2   = 3'd4,
    PH_TAIL  = 3'd5
  } phase_e;

  // Oscillator clocks spent in one CPU phase
  function automatic int unsigned osc_per_phase(input logic x2);
    return x2 ? 1 : 2;
  endfunction

  function automatic phase_e next_phase(input phase_e ph);
    return (ph == PH_TAIL) ? PH_ADDR : phase_e'(ph + 3'd1);
  endfunction

  // Phases in which the controller drives the low address byte
  function automatic logic drives_bus(input phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_HOLD);
  endfunction

  // Phases in which the program-store strobe is active
  function automatic logic reads_bus(input phase_e ph);
    return (ph == PH_RD0) || (ph == PH_RD1) || (ph == PH_RD2);
  endfunction

endpackage

// File: rtl/xfetch_tick_gen.sv
module xfetch_tick_gen
  import xfetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic double_speed,
  output logic mode_x2,
  output logic cpu_tick
);

  logic div_q;

  // The mode bit is taken in only while idle, so that it changes at a cycle boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_x2 <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      if (!busy) begin
        mode_x2 <= double_speed;
        div_q   <= 1'b0;
      end else begin
        div_q   <= ~div_q;
      end
    end
  end

  assign cpu_tick = busy & (mode_x2 | div_q);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_x2));

  // R2
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_x2 && cpu_tick) |=> !cpu_tick);

endmodule

// File: rtl/xfetch_seq.sv
module xfetch_seq
  import xfetch_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_start,
  input  logic   cpu_tick,
  output logic   busy,
  output logic   start_acc,
  output phase_e phase,
  output logic   capture_ev,
  output logic   done_ev
);

  assign start_acc  = req_start & ~busy;
  assign capture_ev = busy & cpu_tick & (phase == PH_RD2);
  assign done_ev    = busy & cpu_tick & (phase == PH_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_ADDR;
    end else if (start_acc) begin
      busy  <= 1'b1;
      phase <= PH_ADDR;
    end else if (busy && cpu_tick) begin
      phase <= next_phase(phase);
      if (phase == PH_TAIL) busy <= 1'b0;
    end
  end

  // R2
  phase_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cpu_tick) |=> (busy && $stable(phase)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start && !cpu_tick) |=> $stable(phase));

  // R7
  capture_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |-> !done_ev);

endmodule

// File: rtl/xfetch_bus.sv
module xfetch_bus
  import xfetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              start_acc,
  input  phase_e            phase,
  input  logic              capture_ev,
  input  logic              done_ev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_table,
  input  logic [DATA_W-1:0] ad_in_i,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_out_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_table
);

  logic [ADDR_W-1:0] addr_q;
  logic              table_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      table_q   <= 1'b0;
      data_q    <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (start_acc) begin
        addr_q  <= req_addr;
        table_q <= req_table;
      end
      if (capture_ev) data_q <= ad_in_i;
      rsp_valid <= done_ev;
    end
  end

  assign addr_hi_o = addr_q[ADDR_W-1:DATA_W];
  assign ad_out_o  = addr_q[DATA_W-1:0];
  assign ale_o     = busy & (phase == PH_ADDR);
  assign ad_oe_o   = busy & drives_bus(phase);
  assign psen_n_o  = ~(busy & reads_bus(phase));
  assign rsp_data  = data_q;
  assign rsp_table = table_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (psen_n_o && !ale_o && !ad_oe_o));

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n_o |-> !ad_oe_o);

  // R5
  ale_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> ad_oe_o);

  // R4
  ale_psen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> psen_n_o);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_hi_o));

endmodule

// File: rtl/xfetch_ctrl.sv
module xfetch_ctrl
  import xfetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              double_speed,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_table,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_table,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_out_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_in_i,
  output logic              ale_o,
  output logic              psen_n_o
);

  logic   mode_x2;
  logic   cpu_tick;
  logic   start_acc;
  logic   capture_ev;
  logic   done_ev;
  phase_e phase;

  xfetch_tick_gen u_tick (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .double_speed (double_speed),
    .mode_x2      (mode_x2),
    .cpu_tick     (cpu_tick)
  );

  xfetch_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .cpu_tick   (cpu_tick),
    .busy       (busy),
    .start_acc  (start_acc),
    .phase      (phase),
    .capture_ev (capture_ev),
    .done_ev    (done_ev)
  );

  xfetch_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .start_acc  (start_acc),
    .phase      (phase),
    .capture_ev (capture_ev),
    .done_ev    (done_ev),
    .req_addr   (req_addr),
    .req_table  (req_table),
    .ad_in_i    (ad_in_i),
    .addr_hi_o  (addr_hi_o),
    .ad_out_o   (ad_out_o),
    .ad_oe_o    (ad_oe_o),
    .ale_o      (ale_o),
    .psen_n_o   (psen_n_o),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_table  (rsp_table)
  );

  // R2
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

endmodule

// File: tb/xfetch_ctrl_test.sv
module xfetch_ctrl_test;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        double_speed = 1'b0;
  logic        req_start = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_table = 1'b0;
  logic        busy, rsp_valid, rsp_table, ad_oe_o, ale_o, psen_n_o;
  logic [7:0]  rsp_data, addr_hi_o, ad_out_o, ad_in_i;
  logic [7:0]  lat_lo = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfetch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .double_speed(double_speed),
    .req_start(req_start), .req_addr(req_addr), .req_table(req_table),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_table(rsp_table),
    .addr_hi_o(addr_hi_o), .ad_out_o(ad_out_o), .ad_oe_o(ad_oe_o),
    .ad_in_i(ad_in_i), .ale_o(ale_o), .psen_n_o(psen_n_o)
  );

  // Memory contents as a function of the address
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h3C;
  endfunction

  // External address latch and memory model
  always @(negedge clk) if (ale_o) lat_lo <= ad_out_o;
  always_comb ad_in_i = !psen_n_o ? mem_byte({addr_hi_o, lat_lo}) : 8'hEE;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic run_txn(input logic [15:0] a, input bit tbl, input bit x2,
                         input bit flip, input bit inject);
    int n;
    int ph;
    n = x2 ? 1 : 2;
    @(negedge clk);
    double_speed = x2;
    req_addr = a;
    req_table = tbl;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int i = 0; i <= 6*n + 1; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1 && inject) begin
        req_start = 1'b1;
        req_addr = ~a;
        req_table = ~tbl;
      end
      if (i == 2) begin
        req_start = 1'b0;
        if (flip) double_speed = ~x2;
      end
      if (i < 6*n) begin
        ph = i / n;
        chk(busy == 1'b1, "R2 busy", busy, 1);
        chk(addr_hi_o == a[15:8], "R3 addr_hi", addr_hi_o, a[15:8]);
        chk(rsp_valid == 1'b0, "R7 no early valid", rsp_valid, 0);
        case (ph)
          0: begin
            chk(ale_o && ad_oe_o && psen_n_o, "R4 strobes", {ale_o, ad_oe_o, psen_n_o}, 3'b111);
            chk(ad_out_o == a[7:0], "R4 low addr", ad_out_o, a[7:0]);
          end
          1: begin
            chk(!ale_o && ad_oe_o && psen_n_o, "R5 strobes", {ale_o, ad_oe_o, psen_n_o}, 3'b011);
            chk(ad_out_o == a[7:0], "R5 low addr", ad_out_o, a[7:0]);
          end
          2, 3, 4:
            chk(!ale_o && !ad_oe_o && !psen_n_o, "R6 read strobes", {ale_o, ad_oe_o, psen_n_o}, 3'b000);
          default:
            chk(!ale_o && !ad_oe_o && psen_n_o, "R6 tail strobes", {ale_o, ad_oe_o, psen_n_o}, 3'b001);
        endcase
      end else if (i == 6*n) begin
        chk(rsp_valid == 1'b1, flip ? "R9 valid timing" : "R2 valid timing", rsp_valid, 1);
        chk(rsp_data == mem_byte(a), inject ? "R8 data" : "R7 data", rsp_data, mem_byte(a));
        chk(rsp_table == tbl, "R10 table flag", rsp_table, tbl);
        chk(busy == 1'b0, "R2 busy end", busy, 0);
        chk(psen_n_o && !ale_o && !ad_oe_o, "R1 idle strobes", {ale_o, ad_oe_o, psen_n_o}, 3'b001);
      end else begin
        chk(rsp_valid == 1'b0, "R7 one-clock valid", rsp_valid, 0);
        chk(busy == 1'b0, "R8 no restart", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R1 reset busy/valid", {busy, rsp_valid}, 0);
    chk(psen_n_o && !ale_o && !ad_oe_o, "R1 reset strobes", {ale_o, ad_oe_o, psen_n_o}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(psen_n_o && !ale_o && !ad_oe_o && !busy, "R1 idle after reset",
        {busy, ale_o, ad_oe_o, psen_n_o}, 4'b0001);
    for (int x2 = 0; x2 < 2; x2++) begin
      for (int tbl = 0; tbl < 2; tbl++) begin
        for (int k = 0; k < 16; k++) begin
          logic [15:0] a;
          a = 16'(k * 16'h1111) ^ (x2 != 0 ? 16'h0F0F : 16'h0000) ^ 16'(tbl * 16'h8001);
          run_txn(a, tbl[0], x2[0], (k % 4) == 1, (k % 3) == 2);
        end
      end
    end
    run_txn(16'h0000, 1'b0, 1'b0, 1'b1, 1'b1);
    run_txn(16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1);
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule